// File: doc/BRIEF.md
# Chunk-Level Cache Line Repair Mux

This block is the data path of a cache that keeps working at low supply voltage. Lines are stored in two banks. Each line is cut into equal chunks, and a per-line fault mask flags the chunks that cannot be trusted. Lines whose fault masks do not overlap are placed in one group. Each group shares a spare line that sits in the opposite bank. On an access, the data line and its spare are read in the same cycle. A per-chunk mux then builds the line that is returned: every flagged chunk comes from the spare, and every other chunk comes from the data line. Writes are split the same way between the two lines.

Software loads, for every line, the fault mask, the row of its spare in the opposite bank and a disable flag. It does this through a configuration port while no access is in progress. A line that could not be placed in any group is disabled and never hits. For high-voltage operation a bypass input turns the repair path off. In that mode the map lookup is held quiet, only the data line is read or written, and reads complete one cycle sooner.

Top module: `chunk_repair_mux`

## Requirements
- R1: A line holds CHUNKS chunks of CHUNK_W bits. Chunk i occupies bits [i*CHUNK_W +: CHUNK_W] of the line, and bit i of a line's fault mask refers to chunk i.
- R2: A line address is {bank, row}, with the most significant bit selecting the bank. The spare of a line lies in the other bank, at the row stored for that line. Lines with disjoint fault masks may share one spare, and each of them reads back its own data.
- R3: In repair mode, read chunk i is taken from the spare when fault bit i is set, and from the data line otherwise.
- R4: In repair mode, a write stores healthy chunks into the data line and flagged chunks into the same positions of the spare. The data line's flagged chunks and the spare's other chunks are left unchanged.
- R5: In repair mode, a read answers with rsp_valid and rsp_hit high at the second rising edge after the request edge, and rsp_valid is low after the first.
- R6: With bypass high, a read answers at the first rising edge after the request, always with a hit. Fault masks and disable flags are ignored, and a write stores the whole line into the data line only.
- R7: In repair mode, a read of a disabled line answers with rsp_hit low and rsp_rdata zero. A write to it changes neither the data line nor its spare.
- R8: A configuration write sets a line's fault mask, spare row and disable flag, and these take effect from the next access. Reset clears every mask and flag and sets every spare row to 0, and rsp_valid is low after reset.
- R9: A write request never produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | High-voltage mode: repair path off |
| cfg_we | input | 1 | Map configuration write strobe |
| cfg_line | input | ROW_W+1 | Line whose map entry is written |
| cfg_fault | input | CHUNKS | Fault mask, one bit per chunk |
| cfg_spare_row | input | ROW_W | Spare row in the opposite bank |
| cfg_off | input | 1 | Disable flag for the line |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | ROW_W+1 | Line address {bank, row} |
| req_wdata | input | CHUNKS*CHUNK_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_hit | output | 1 | Line usable (low for disabled line) |
| rsp_rdata | output | CHUNKS*CHUNK_W | Read data after repair |

## Verification
The checks assume that configuration writes never share a cycle with an access. They also assume that bypass changes only while no read is in flight, so the one-cycle and two-cycle response paths never meet in the same cycle. The bench changes mode and maps only between completed transactions, with idle cycles on both sides, and it issues one request at a time. Groups in the randomized scenario are built so that no chunk position is flagged in two members of one group.

// File: rtl/crm_pkg.sv
package crm_pkg;

    parameter int unsigned DEF_CHUNKS  = 8;
    parameter int unsigned DEF_CHUNK_W = 8;
    parameter int unsigned DEF_ROWS    = 16;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // bank that holds the spare for a line stored in bank b
    function automatic logic spare_bank(input logic b);
        return ~b;
    endfunction

endpackage

// File: rtl/crm_map.sv
module crm_map #(
    parameter int unsigned CHUNKS = crm_pkg::DEF_CHUNKS,
    parameter int unsigned ROWS   = crm_pkg::DEF_ROWS,
    localparam int unsigned ROW_W = $clog2(ROWS),
    localparam int unsigned LINES = 2 * ROWS,
    localparam int unsigned LINE_W = ROW_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic [CHUNKS-1:0] cfg_fault,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic              cfg_off,
    input  logic              lk_en,
    input  logic [LINE_W-1:0] lk_line,
    output logic [CHUNKS-1:0] lk_fault,
    output logic [ROW_W-1:0]  lk_row,
    output logic              lk_off
);

    logic [CHUNKS-1:0] fault_q [LINES];
    logic [ROW_W-1:0]  row_q   [LINES];
    logic              off_q   [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(LINES); i++) begin
                fault_q[i] <= '0;
                row_q[i]   <= '0;
                off_q[i]   <= 1'b0;
            end
        end else if (cfg_we) begin
            fault_q[cfg_line] <= cfg_fault;
            row_q[cfg_line]   <= cfg_row;
            off_q[cfg_line]   <= cfg_off;
        end
    end

    // lookup port is held at zero when the repair path is off
    always_comb begin
        if (lk_en) begin
            lk_fault = fault_q[lk_line];
            lk_row   = row_q[lk_line];
            lk_off   = off_q[lk_line];
        end else begin
            lk_fault = '0;
            lk_row   = '0;
            lk_off   = 1'b0;
        end
    end

endmodule

// File: rtl/crm_bank.sv
module crm_bank #(
    parameter int unsigned CHUNKS  = crm_pkg::DEF_CHUNKS,
    parameter int unsigned CHUNK_W = crm_pkg::DEF_CHUNK_W,
    parameter int unsigned ROWS    = crm_pkg::DEF_ROWS,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned LINE_BITS = CHUNKS * CHUNK_W
) (
    input  logic                 clk,
    input  logic                 rd_en,
    input  logic [ROW_W-1:0]     row,
    input  logic [CHUNKS-1:0]    we_mask,
    input  logic [LINE_BITS-1:0] wr_data,
    output logic [LINE_BITS-1:0] rd_data
);

    // one storage column per chunk so that chunk enables stay independent
    for (genvar c = 0; c < int'(CHUNKS); c++) begin : g_col
        logic [CHUNK_W-1:0] col [ROWS];
        logic [CHUNK_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we_mask[c]) begin
                col[row] <= wr_data[c*CHUNK_W +: CHUNK_W];
            end
            if (rd_en) begin
                rd_q <= col[row];
            end
        end

        assign rd_data[c*CHUNK_W +: CHUNK_W] = rd_q;
    end

endmodule

// File: rtl/crm_merge.sv
module crm_merge #(
    parameter int unsigned CHUNKS  = crm_pkg::DEF_CHUNKS,
    parameter int unsigned CHUNK_W = crm_pkg::DEF_CHUNK_W,
    localparam int unsigned LINE_BITS = CHUNKS * CHUNK_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_off,
    input  logic [CHUNKS-1:0]    in_fault,
    input  logic [LINE_BITS-1:0] data_word,
    input  logic [LINE_BITS-1:0] spare_word,
    output logic                 out_valid,
    output logic                 out_hit,
    output logic [LINE_BITS-1:0] out_data
);

    logic [LINE_BITS-1:0] merged;

    for (genvar c = 0; c < int'(CHUNKS); c++) begin : g_sel
        assign merged[c*CHUNK_W +: CHUNK_W] = in_fault[c]
            ? spare_word[c*CHUNK_W +: CHUNK_W]
            : data_word[c*CHUNK_W +: CHUNK_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_valid & ~in_off;
            out_data  <= (in_valid & ~in_off) ? merged : '0;
        end
    end

    // R5: a repaired response is always preceded by a first-stage read
    a_r5_merge_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

endmodule

// File: rtl/chunk_repair_mux.sv
module chunk_repair_mux #(
    parameter int unsigned CHUNKS  = crm_pkg::DEF_CHUNKS,
    parameter int unsigned CHUNK_W = crm_pkg::DEF_CHUNK_W,
    parameter int unsigned ROWS    = crm_pkg::DEF_ROWS,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned LINE_W = ROW_W + 1,
    localparam int unsigned LINE_BITS = CHUNKS * CHUNK_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bypass,
    input  logic                 cfg_we,
    input  logic [LINE_W-1:0]    cfg_line,
    input  logic [CHUNKS-1:0]    cfg_fault,
    input  logic [ROW_W-1:0]     cfg_spare_row,
    input  logic                 cfg_off,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [LINE_W-1:0]    req_line,
    input  logic [LINE_BITS-1:0] req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [LINE_BITS-1:0] rsp_rdata
);
    import crm_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              bank;
        logic              byp;
        logic              off;
        logic [CHUNKS-1:0] fault;
    } stage1_t;

    op_e               req_op;
    logic              req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [CHUNKS-1:0] lk_fault;
    logic [ROW_W-1:0]  lk_row;
    logic              lk_off;

    logic [LINE_BITS-1:0] bank_rd [2];
    logic [CHUNKS-1:0]    bank_we [2];

    stage1_t s1_q;
    logic [LINE_BITS-1:0] data_word;
    logic [LINE_BITS-1:0] spare_word;
    logic                 byp_valid;
    logic                 m_valid;
    logic                 m_hit;
    logic [LINE_BITS-1:0] m_data;

    always_comb begin
        if (!req_valid)     req_op = OP_NONE;
        else if (req_write) req_op = OP_WRITE;
        else                req_op = OP_READ;
    end

    assign req_bank = req_line[LINE_W-1];
    assign req_row  = req_line[ROW_W-1:0];

    crm_map #(.CHUNKS(CHUNKS), .ROWS(ROWS)) u_map (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_line (cfg_line),
        .cfg_fault(cfg_fault),
        .cfg_row  (cfg_spare_row),
        .cfg_off  (cfg_off),
        .lk_en    (~bypass),
        .lk_line  (req_line),
        .lk_fault (lk_fault),
        .lk_row   (lk_row),
        .lk_off   (lk_off)
    );

    for (genvar k = 0; k < 2; k++) begin : g_bank
        logic              is_data;
        logic              is_spare;
        logic [ROW_W-1:0]  row;
        logic              rd_en;
        logic [CHUNKS-1:0] we;

        assign is_data  = (req_bank == 1'(k));
        assign is_spare = (spare_bank(req_bank) == 1'(k));
        assign row      = is_data ? req_row : lk_row;
        assign rd_en    = (req_op == OP_READ) && (is_data || !bypass);

        always_comb begin
            we = '0;
            if (req_op == OP_WRITE) begin
                if (bypass)
                    we = is_data ? '1 : '0;
                else if (!lk_off)
                    we = is_data ? ~lk_fault : (is_spare ? lk_fault : '0);
            end
        end

        assign bank_we[k] = we;

        crm_bank #(.CHUNKS(CHUNKS), .CHUNK_W(CHUNK_W), .ROWS(ROWS)) u_bank (
            .clk    (clk),
            .rd_en  (rd_en),
            .row    (row),
            .we_mask(we),
            .wr_data(req_wdata),
            .rd_data(bank_rd[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= (req_op == OP_READ);
            s1_q.bank  <= req_bank;
            s1_q.byp   <= bypass;
            s1_q.off   <= lk_off;
            s1_q.fault <= lk_fault;
        end
    end

    assign data_word  = s1_q.bank ? bank_rd[1] : bank_rd[0];
    assign spare_word = s1_q.bank ? bank_rd[0] : bank_rd[1];
    assign byp_valid  = s1_q.valid & s1_q.byp;

    crm_merge #(.CHUNKS(CHUNKS), .CHUNK_W(CHUNK_W)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s1_q.valid & ~s1_q.byp),
        .in_off    (s1_q.off),
        .in_fault  (s1_q.fault),
        .data_word (data_word),
        .spare_word(spare_word),
        .out_valid (m_valid),
        .out_hit   (m_hit),
        .out_data  (m_data)
    );

    assign rsp_valid = byp_valid | m_valid;
    assign rsp_hit   = byp_valid | m_hit;
    assign rsp_rdata = byp_valid ? data_word : m_data;

    // R2: a chunk position is never written in both banks in one cycle
    a_r2_disjoint_we: assert property (@(posedge clk) disable iff (rst)
        (bank_we[0] & bank_we[1]) == '0);

    // R6: bypass reads answer one edge later with a hit
    a_r6_bypass_latency: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && bypass) |=> (rsp_valid && rsp_hit));

    // R6: the two response paths never fire together
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(byp_valid && m_valid));

    // R5: repaired reads answer two edges later
    a_r5_repair_latency: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !bypass) |=> ##1 rsp_valid);

    // R7: a disabled line never hits and returns zero
    a_r7_off_nohit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !bypass && lk_off)
            |=> ##1 (rsp_valid && !rsp_hit && rsp_rdata == '0));

    // R9: every response traces back to a read request
    a_r9_resp_from_read: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && !req_write)
                       || $past(req_valid && !req_write, 2)));

    // R8: maps are only loaded while no access is in progress
    a_r8_cfg_idle: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> !req_valid);

endmodule

// File: tb/tb_chunk_repair_mux.sv
module tb_chunk_repair_mux;

    localparam int CH   = 8;
    localparam int CW   = 8;
    localparam int ROWS = 16;
    localparam int RW   = 4;
    localparam int LWID = RW + 1;
    localparam int LB   = CH * CW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bypass = 1'b0;
    logic cfg_we = 1'b0;
    logic [LWID-1:0] cfg_line = '0;
    logic [CH-1:0]   cfg_fault = '0;
    logic [RW-1:0]   cfg_spare_row = '0;
    logic            cfg_off = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [LWID-1:0] req_line = '0;
    logic [LB-1:0]   req_wdata = '0;
    logic            rsp_valid;
    logic            rsp_hit;
    logic [LB-1:0]   rsp_rdata;

    always #5 clk = ~clk;

    chunk_repair_mux #(.CHUNKS(CH), .CHUNK_W(CW), .ROWS(ROWS)) dut (
        .clk(clk), .rst(rst), .bypass(bypass),
        .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_fault(cfg_fault),
        .cfg_spare_row(cfg_spare_row), .cfg_off(cfg_off),
        .req_valid(req_valid), .req_write(req_write), .req_line(req_line),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // golden model
    logic [LB-1:0]  gm [2][ROWS];
    logic [CH-1:0]  mf [2*ROWS];
    logic [RW-1:0]  mr [2*ROWS];
    logic           mo [2*ROWS];

    task automatic check(input bit ok, input string req, input logic [LB-1:0] act,
                         input logic [LB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic b);
        @(negedge clk);
        bypass = b;
        @(negedge clk);
    endtask

    task automatic do_cfg(input int line, input logic [CH-1:0] f, input int row, input logic off);
        @(negedge clk);
        cfg_we = 1'b1; cfg_line = LWID'(line); cfg_fault = f;
        cfg_spare_row = RW'(row); cfg_off = off;
        @(negedge clk);
        cfg_we = 1'b0;
        mf[line] = f; mr[line] = RW'(row); mo[line] = off;
    endtask

    task automatic do_write(input int line, input logic [LB-1:0] d, input string req);
        int b, r, sb;
        b = line / ROWS; r = line % ROWS; sb = 1 - b;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_line = LWID'(line); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check(rsp_valid == 1'b0, req, LB'(rsp_valid), '0);
        @(negedge clk);
        check(rsp_valid == 1'b0, req, LB'(rsp_valid), '0);
        if (bypass) begin
            gm[b][r] = d;
        end else if (!mo[line]) begin
            for (int c = 0; c < CH; c++) begin
                if (mf[line][c]) gm[sb][mr[line]][c*CW +: CW] = d[c*CW +: CW];
                else             gm[b][r][c*CW +: CW] = d[c*CW +: CW];
            end
        end
    endtask

    task automatic do_read(input int line, input string req);
        int b, r, sb;
        logic [LB-1:0] exp;
        logic ehit;
        b = line / ROWS; r = line % ROWS; sb = 1 - b;
        if (bypass) begin
            exp = gm[b][r]; ehit = 1'b1;
        end else if (mo[line]) begin
            exp = '0; ehit = 1'b0;
        end else begin
            ehit = 1'b1;
            for (int c = 0; c < CH; c++)
                exp[c*CW +: CW] = mf[line][c] ? gm[sb][mr[line]][c*CW +: CW]
                                              : gm[b][r][c*CW +: CW];
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_line = LWID'(line);
        @(negedge clk);
        req_valid = 1'b0;
        if (!bypass) begin
            check(rsp_valid == 1'b0, {req, " early"}, LB'(rsp_valid), '0);
            @(negedge clk);
        end
        check(rsp_valid == 1'b1, {req, " valid"}, LB'(rsp_valid), LB'(1));
        check(rsp_hit == ehit, {req, " hit"}, LB'(rsp_hit), LB'(ehit));
        check(rsp_rdata == exp, {req, " data"}, rsp_rdata, exp);
    endtask

    task automatic t_reset;
        check(rsp_valid == 1'b0, "R8 reset", LB'(rsp_valid), '0);
        set_mode(1'b1);
        for (int i = 0; i < 2*ROWS; i++)
            do_write(i, {32'(i), 32'hC0DE_0000 + 32'(i)}, "R9 init write");
        set_mode(1'b0);
        do_read(3, "R8 cleared map reads data line");
        do_read(17, "R8 cleared map bank1");
    endtask

    task automatic t_bypass;
        set_mode(1'b1);
        do_cfg(5, 8'hFF, 2, 1'b0);
        do_cfg(6, 8'h00, 3, 1'b1);
        do_write(5, 64'h1122_3344_5566_7788, "R6 bypass write");
        do_read(5, "R6 bypass ignores faults");
        do_read(6, "R6 bypass ignores disable");
        do_read(16 + 2, "R6 bypass spare untouched");
    endtask

    task automatic t_repair;
        set_mode(1'b0);
        do_cfg(2, 8'b0010_0101, 9, 1'b0);
        do_write(2, 64'hA1A2_A3A4_A5A6_A7A8, "R4 repair write");
        do_read(2, "R3 repair read");
        check(rsp_rdata == 64'hA1A2_A3A4_A5A6_A7A8, "R1 chunk layout", rsp_rdata,
              64'hA1A2_A3A4_A5A6_A7A8);
        set_mode(1'b1);
        do_read(2, "R4 data line keeps flagged chunks");
        do_read(16 + 9, "R4 spare holds flagged chunks");
    endtask

    task automatic t_group;
        set_mode(1'b0);
        do_cfg(1, 8'h0F, 10, 1'b0);
        do_cfg(4, 8'hF0, 10, 1'b0);
        do_write(1, 64'h0101_0202_0303_0404, "R2 group member a");
        do_write(4, 64'hF0F1_F2F3_F4F5_F6F7, "R2 group member b");
        do_read(1, "R2 shared spare a");
        check(rsp_rdata == 64'h0101_0202_0303_0404, "R2 own data a", rsp_rdata,
              64'h0101_0202_0303_0404);
        do_read(4, "R2 shared spare b");
        check(rsp_rdata == 64'hF0F1_F2F3_F4F5_F6F7, "R2 own data b", rsp_rdata,
              64'hF0F1_F2F3_F4F5_F6F7);
    endtask

    task automatic t_disabled;
        set_mode(1'b0);
        do_cfg(20, 8'h3C, 11, 1'b1);
        do_write(20, 64'hDEAD_BEEF_DEAD_BEEF, "R7 write to disabled");
        do_read(20, "R7 disabled read");
        set_mode(1'b1);
        do_read(20, "R7 data line unchanged");
        do_read(11, "R7 spare unchanged");
    endtask

    task automatic t_random;
        logic [LB-1:0] wr [2][12];
        set_mode(1'b0);
        for (int b = 0; b < 2; b++) begin
            for (int g = 0; g < 4; g++) begin
                logic [CH-1:0] f [3];
                for (int m = 0; m < 3; m++) f[m] = '0;
                for (int c = 0; c < CH; c++) begin
                    int pick = int'($urandom % 4);
                    if (pick < 3) f[pick][c] = 1'b1;
                end
                for (int m = 0; m < 3; m++)
                    do_cfg(b*ROWS + g + 4*m, f[m], 12 + g, 1'b0);
            end
        end
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 12; r++) begin
                wr[b][r] = {$urandom, $urandom};
                do_write(b*ROWS + r, wr[b][r], "R4 random write");
            end
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 12; r++) begin
                do_read(b*ROWS + r, "R3 random read");
                check(rsp_rdata == wr[b][r], "R2 random own data", rsp_rdata, wr[b][r]);
            end
    endtask

    initial begin
        for (int i = 0; i < 2*ROWS; i++) begin
            mf[i] = '0; mr[i] = '0; mo[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bypass();
        t_repair();
        t_group();
        t_disabled();
        t_random();
        set_mode(1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule